// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the scan timing for a display pipeline running on a single pixel clock. A horizontal pixel counter and a vertical line counter sweep the raster. Programmable windows on those counters drive a blanking strobe, a display-enable strobe, a sync pulse pair for a monitor and a second, independently placed sync pair for a flat panel. The current pixel and line positions are also brought out for downstream logic.

Software sets the block up over a small word-addressed register bus. Each timing word holds two 16-bit halves: a start or active value, and an end or total value. Every value is the last position it covers, that is, the count minus one. A key register guards all configuration. A write of the key opens the configuration registers, and a write of any other value closes them again.

Timing words programmed while the raster runs are copied into the working set only when a frame ends. A frame that is being scanned therefore always uses one consistent set of values. While the generator is stopped, the working set follows the programmed words.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is held, and in the cycle after it is released, both counters read zero, all six strobe outputs are low, and every register reads zero.
- R2: The registers sit at word offsets 0 (key), 1 (config), 2 (horizontal active/total), 3 (horizontal blank start/end), 4 (horizontal sync start/end), 5 (vertical active/total), 6 (vertical blank start/end), 7 (vertical sync start/end), 8 (panel horizontal sync start/end) and 9 (panel vertical sync start/end). In each timing word, bits [15:0] hold the active or start value and bits [31:16] hold the total or end value. `bus_rdata` combinationally returns the current contents of the register at `bus_addr`, and returns zero for offsets 10 to 15.
- R3: A write to offset 0 is always accepted. Writes to offsets 1 to 9 take effect only while offset 0 holds 32'h0000_4758. At any other time they are dropped, and the register keeps its value.
- R4: Config bit 0 is the run enable. While it is clear, both counters are zero and `hsync`, `vsync`, `blank`, `disp_en`, `pnl_hsync` and `pnl_vsync` are low.
- R5: While run is set, the pixel counter steps by one every clock and wraps to 0 after reaching the horizontal total. The line counter steps on that wrap and returns to 0 after the vertical total. After run is set, the first cycle in which run is visible shows pixel 0, line 0.
- R6: `hsync` is high when run and config bit 2 are set and start <= pixel <= end of the horizontal sync word. `vsync` follows the same rule with config bit 3, the vertical sync word and the line counter. A start value above the end value never asserts the strobe.
- R7: With config bit 1 set, `blank` is high when the pixel lies inside the horizontal blank window or the line lies inside the vertical blank window. In that case `disp_en` is high only when the pixel <= horizontal active, the line <= vertical active, and `blank` is low.
- R8: With config bit 1 clear, `blank` stays low and `disp_en` is high exactly when the pixel <= horizontal active and the line <= vertical active.
- R9: `pnl_hsync` and `pnl_vsync` follow the inclusive window rule on the panel words at offsets 8 and 9. They are gated by run and config bit 4, independently of the monitor sync words and enables.
- R10: A timing word written while run is set takes effect in the cycle that shows pixel 0, line 0 after the current frame ends. While run is clear, a written word takes effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Register word offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Contents of the addressed register |
| hsync | output | 1 | Monitor horizontal sync, active high |
| vsync | output | 1 | Monitor vertical sync, active high |
| blank | output | 1 | Blanking strobe |
| disp_en | output | 1 | Visible-pixel strobe |
| pnl_hsync | output | 1 | Panel horizontal sync |
| pnl_vsync | output | 1 | Panel vertical sync |
| pix_x | output | 16 | Current pixel position |
| line_y | output | 16 | Current line position |

## Verification
The raster is first run on a small 12-by-7 mode with every enable set, so that both wraps and every window edge appear within a few frames. The enable mix is then varied: blanking off and vertical sync off separate the R7 and R8 display-enable rules and show that each sync gate is independent. Some timing words are rewritten in mid-frame, including a horizontal sync window with its start above its end. Any early use of these words shows up as a counter or strobe mismatch before the frame boundary. Writes made while locked, and while the wrong key is held, are read back through the bus, and single-position windows check the inclusive end points.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned HALF_W  = 16;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned NUM_TIM = 8;
  localparam int unsigned CFG_W   = 5;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_4758;

  localparam int unsigned ADDR_KEY  = 0;
  localparam int unsigned ADDR_CFG  = 1;
  localparam int unsigned ADDR_TIM0 = 2;

  // timing word indices (offset = index + ADDR_TIM0)
  localparam int unsigned T_HMAIN  = 0;
  localparam int unsigned T_HBLANK = 1;
  localparam int unsigned T_HSYNC  = 2;
  localparam int unsigned T_VMAIN  = 3;
  localparam int unsigned T_VBLANK = 4;
  localparam int unsigned T_VSYNC  = 5;
  localparam int unsigned T_PHSYNC = 6;
  localparam int unsigned T_PVSYNC = 7;

  // config bit positions
  localparam int unsigned C_RUN   = 0;
  localparam int unsigned C_BLANK = 1;
  localparam int unsigned C_HSYNC = 2;
  localparam int unsigned C_VSYNC = 3;
  localparam int unsigned C_PANEL = 4;

  function automatic logic [HALF_W-1:0] lo_half(input logic [DATA_W-1:0] w);
    return w[HALF_W-1:0];
  endfunction

  function automatic logic [HALF_W-1:0] hi_half(input logic [DATA_W-1:0] w);
    return w[DATA_W-1:HALF_W];
  endfunction

  // inclusive window: start <= c <= end
  function automatic logic in_window(input logic [HALF_W-1:0] c,
                                     input logic [DATA_W-1:0] w);
    return (c >= lo_half(w)) && (c <= hi_half(w));
  endfunction
endpackage

// File: rtl/tg_regs.sv
module tg_regs
  import raster_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic                           bus_wr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic [CFG_W-1:0]               cfg_q,
  output logic [NUM_TIM-1:0][DATA_W-1:0] tim_q
);
  logic [DATA_W-1:0] key_q;
  logic [DATA_W-1:0] tim_r [NUM_TIM];
  logic              unlocked;
  logic              wr_key;
  logic              wr_dropped;

  assign unlocked   = (key_q == UNLOCK_KEY);
  assign wr_key     = bus_wr && (bus_addr == ADDR_W'(ADDR_KEY));
  assign wr_dropped = bus_wr && !wr_key && !unlocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= '0;
      cfg_q <= '0;
      for (int k = 0; k < NUM_TIM; k++) tim_r[k] <= '0;
    end else begin
      if (wr_key) key_q <= bus_wdata;
      if (bus_wr && unlocked) begin
        if (bus_addr == ADDR_W'(ADDR_CFG)) cfg_q <= bus_wdata[CFG_W-1:0];
        for (int k = 0; k < NUM_TIM; k++)
          if (bus_addr == ADDR_W'(ADDR_TIM0 + k)) tim_r[k] <= bus_wdata;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_TIM; k++) tim_q[k] = tim_r[k];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADDR_KEY)) bus_rdata = key_q;
    if (bus_addr == ADDR_W'(ADDR_CFG)) bus_rdata = DATA_W'(cfg_q);
    for (int k = 0; k < NUM_TIM; k++)
      if (bus_addr == ADDR_W'(ADDR_TIM0 + k)) bus_rdata = tim_r[k];
  end

  assert_locked_write_dropped_R3: assert property (@(posedge clk) disable iff (rst)
    wr_dropped |=> ($stable(cfg_q) && $stable(tim_q)));
endmodule

// File: rtl/tg_counter.sv
module tg_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = run && step && (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (wrap)    cnt <= '0;
    else if (step)    cnt <= cnt + W'(1);
  end

  assert_within_last_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= last);

  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    (run && step && !wrap) |=> (cnt == $past(cnt) + W'(1)));
endmodule

// File: rtl/tg_shadow.sv
module tg_shadow
  import raster_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           load,
  input  logic [NUM_TIM-1:0][DATA_W-1:0] tim_in,
  output logic [NUM_TIM-1:0][DATA_W-1:0] tim_out
);
  always_ff @(posedge clk) begin
    if (rst)       tim_out <= '0;
    else if (load) tim_out <= tim_in;
  end
endmodule

// File: rtl/tg_decode.sv
module tg_decode
  import raster_pkg::*;
(
  input  logic [CFG_W-1:0]  cfg,
  input  logic [HALF_W-1:0] h,
  input  logic [HALF_W-1:0] v,
  input  logic [HALF_W-1:0] h_act,
  input  logic [HALF_W-1:0] v_act,
  input  logic [DATA_W-1:0] w_hblank,
  input  logic [DATA_W-1:0] w_hsync,
  input  logic [DATA_W-1:0] w_vblank,
  input  logic [DATA_W-1:0] w_vsync,
  input  logic [DATA_W-1:0] w_phsync,
  input  logic [DATA_W-1:0] w_pvsync,
  output logic              hsync,
  output logic              vsync,
  output logic              blank,
  output logic              disp_en,
  output logic              pnl_hsync,
  output logic              pnl_vsync
);
  logic run;
  logic blank_raw;
  logic in_active;

  assign run       = cfg[C_RUN];
  assign blank_raw = in_window(h, w_hblank) || in_window(v, w_vblank);
  assign in_active = (h <= h_act) && (v <= v_act);

  assign hsync     = run && cfg[C_HSYNC] && in_window(h, w_hsync);
  assign vsync     = run && cfg[C_VSYNC] && in_window(v, w_vsync);
  assign blank     = run && cfg[C_BLANK] && blank_raw;
  assign disp_en   = run && in_active && !(cfg[C_BLANK] && blank_raw);
  assign pnl_hsync = run && cfg[C_PANEL] && in_window(h, w_phsync);
  assign pnl_vsync = run && cfg[C_PANEL] && in_window(v, w_pvsync);

  always_comb begin
    assert_de_not_blank_R7: assert (!(disp_en && blank));
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              hsync,
  output logic              vsync,
  output logic              blank,
  output logic              disp_en,
  output logic              pnl_hsync,
  output logic              pnl_vsync,
  output logic [15:0]       pix_x,
  output logic [15:0]       line_y
);
  logic [CFG_W-1:0]               cfg_q;
  logic [NUM_TIM-1:0][DATA_W-1:0] tim_live;
  logic [NUM_TIM-1:0][DATA_W-1:0] tim_act;
  logic                           run;
  logic                           h_wrap;
  logic                           v_wrap;
  logic                           frame_end;
  logic                           shadow_load;

  tg_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_q     (cfg_q),
    .tim_q     (tim_live)
  );

  assign run         = cfg_q[C_RUN];
  assign frame_end   = h_wrap && v_wrap;
  assign shadow_load = !run || frame_end;

  tg_shadow u_shadow (
    .clk     (clk),
    .rst     (rst),
    .load    (shadow_load),
    .tim_in  (tim_live),
    .tim_out (tim_act)
  );

  tg_counter #(.W(HALF_W)) u_hcnt (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .step (1'b1),
    .last (hi_half(tim_act[T_HMAIN])),
    .cnt  (pix_x),
    .wrap (h_wrap)
  );

  tg_counter #(.W(HALF_W)) u_vcnt (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .step (h_wrap),
    .last (hi_half(tim_act[T_VMAIN])),
    .cnt  (line_y),
    .wrap (v_wrap)
  );

  tg_decode u_decode (
    .cfg       (cfg_q),
    .h         (pix_x),
    .v         (line_y),
    .h_act     (lo_half(tim_act[T_HMAIN])),
    .v_act     (lo_half(tim_act[T_VMAIN])),
    .w_hblank  (tim_act[T_HBLANK]),
    .w_hsync   (tim_act[T_HSYNC]),
    .w_vblank  (tim_act[T_VBLANK]),
    .w_vsync   (tim_act[T_VSYNC]),
    .w_phsync  (tim_act[T_PHSYNC]),
    .w_pvsync  (tim_act[T_PVSYNC]),
    .hsync     (hsync),
    .vsync     (vsync),
    .blank     (blank),
    .disp_en   (disp_en),
    .pnl_hsync (pnl_hsync),
    .pnl_vsync (pnl_vsync)
  );

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pix_x == '0 && line_y == '0));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !run |-> !(hsync || vsync || blank || disp_en || pnl_hsync || pnl_vsync));

  assert_frame_restart_R5: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (pix_x == '0 && line_y == '0));

  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (run && !frame_end) |=> $stable(tim_act));
endmodule

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;
  localparam logic [31:0] KEY = 32'h0000_4758;
  localparam time WD_LIMIT = 2_000_000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hsync, vsync, blank, disp_en, pnl_hsync, pnl_vsync;
  logic [15:0] pix_x, line_y;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit lock_phase = 1'b0;
  bit shadow_phase = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  raster_timing_gen i_raster_timing_gen (
    .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_wr (bus_wr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .hsync (hsync),
    .vsync (vsync), .blank (blank), .disp_en (disp_en),
    .pnl_hsync (pnl_hsync), .pnl_vsync (pnl_vsync),
    .pix_x (pix_x), .line_y (line_y)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_key;
  logic [4:0]  m_cfg;
  logic [31:0] m_regs [8];
  logic [31:0] m_act  [8];
  int          m_h, m_v;

  function automatic int lo16(logic [31:0] w); return int'(w[15:0]);  endfunction
  function automatic int hi16(logic [31:0] w); return int'(w[31:16]); endfunction
  function automatic bit inw(int c, logic [31:0] w);
    return (c >= lo16(w)) && (c <= hi16(w));
  endfunction

  always @(posedge clk) begin : model
    int nh, nv;
    bit run, fend;
    if (rst) begin
      m_key = '0; m_cfg = '0; m_h = 0; m_v = 0;
      for (int k = 0; k < 8; k++) begin m_regs[k] = '0; m_act[k] = '0; end
    end else begin
      run  = m_cfg[0];
      fend = run && (m_h >= hi16(m_act[0])) && (m_v >= hi16(m_act[3]));
      if (!run) begin nh = 0; nv = 0; end
      else if (m_h >= hi16(m_act[0])) begin
        nh = 0;
        nv = (m_v >= hi16(m_act[3])) ? 0 : m_v + 1;
      end else begin nh = m_h + 1; nv = m_v; end
      if (!run || fend)
        for (int k = 0; k < 8; k++) m_act[k] = m_regs[k];
      if (bus_wr) begin
        if (bus_addr == 4'd0) m_key = bus_wdata;
        else if (m_key == KEY) begin
          if (bus_addr == 4'd1) m_cfg = bus_wdata[4:0];
          else if (bus_addr >= 4'd2 && bus_addr <= 4'd9)
            m_regs[int'(bus_addr) - 2] = bus_wdata;
        end
      end
      m_h = nh; m_v = nv;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_rdata(logic [3:0] a);
    if (a == 4'd0) return m_key;
    if (a == 4'd1) return {27'd0, m_cfg};
    if (a <= 4'd9) return m_regs[int'(a) - 2];
    return '0;
  endfunction

  always @(negedge clk) begin : compare
    bit run, braw, act;
    string tc, tb;
    if (cmp_on && !rst) begin
      run  = m_cfg[0];
      braw = inw(m_h, m_act[1]) || inw(m_v, m_act[4]);
      act  = (m_h <= lo16(m_act[0])) && (m_v <= lo16(m_act[3]));
      tc   = !run ? "R4" : (shadow_phase ? "R10" : "R5");
      tb   = !run ? "R4" : (m_cfg[1] ? "R7" : "R8");
      chk(tc, {16'd0, pix_x}, 32'(m_h));
      chk(tc, {16'd0, line_y}, 32'(m_v));
      chk(run ? "R6" : "R4", {30'd0, hsync, vsync},
          {30'd0, run && m_cfg[2] && inw(m_h, m_act[2]),
                  run && m_cfg[3] && inw(m_v, m_act[5])});
      chk(tb, {30'd0, blank, disp_en},
          {30'd0, run && m_cfg[1] && braw, run && act && !(m_cfg[1] && braw)});
      chk(run ? "R9" : "R4", {30'd0, pnl_hsync, pnl_vsync},
          {30'd0, run && m_cfg[4] && inw(m_h, m_act[6]),
                  run && m_cfg[4] && inw(m_v, m_act[7])});
      chk(lock_phase ? "R3" : "R2", bus_rdata, exp_rdata(bus_addr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic program_base;
    wr(4'd2, {16'd11, 16'd7});  // h total 12, active 8
    wr(4'd3, {16'd11, 16'd8});  // h blank 8..11
    wr(4'd4, {16'd10, 16'd9});  // h sync 9..10
    wr(4'd5, {16'd6,  16'd3});  // v total 7, active 4
    wr(4'd6, {16'd6,  16'd4});  // v blank 4..6
    wr(4'd7, {16'd5,  16'd5});  // v sync line 5
    wr(4'd8, {16'd10, 16'd8});  // panel h sync 8..10
    wr(4'd9, {16'd4,  16'd4});  // panel v sync one line ahead
  endtask

  initial begin
    idle(3);
    // R1: outputs during reset
    chk("R1", {16'd0, pix_x}, 32'd0);
    chk("R1", {26'd0, hsync, vsync, blank, disp_en, pnl_hsync, pnl_vsync}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {line_y, pix_x}, 32'd0);
    chk("R1", {26'd0, hsync, vsync, blank, disp_en, pnl_hsync, pnl_vsync}, 32'd0);
    for (int a = 0; a < 16; a++) begin
      bus_addr = 4'(a); #1;
      chk("R1", bus_rdata, 32'd0);
      @(negedge clk);
    end
    cmp_on = 1'b1;

    // R3: locked writes are dropped
    lock_phase = 1'b1;
    wr(4'd1, 32'h1f);
    wr(4'd2, 32'h1234_5678);
    bus_addr = 4'd1; idle(3);
    bus_addr = 4'd2; idle(3);
    lock_phase = 1'b0;

    // R2: unlock and program, then read back every offset
    wr(4'd0, KEY);
    program_base();
    for (int a = 0; a < 16; a++) begin bus_addr = 4'(a); idle(2); end

    // R5/R6/R7/R9: all enables
    wr(4'd1, 32'h1f);
    bus_addr = 4'd1;
    idle(260);

    // R8 and independent gates: blank off, vsync off
    wr(4'd1, 32'h15);
    idle(200);

    // R10: rewrite timing mid-frame, including an inverted sync window
    wr(4'd1, 32'h1f);
    idle(30);
    shadow_phase = 1'b1;
    wr(4'd4, {16'd3, 16'd9});
    wr(4'd2, {16'd15, 16'd9});
    idle(300);
    shadow_phase = 1'b0;

    // R4: stop mid-frame, rewrite while stopped
    wr(4'd1, 32'h1e);
    idle(20);
    wr(4'd4, {16'd5, 16'd5});
    idle(10);

    // R3: relock, wrong key, dropped writes
    lock_phase = 1'b1;
    wr(4'd0, 32'd0);
    wr(4'd1, 32'h1f);
    bus_addr = 4'd1; idle(10);
    wr(4'd0, KEY + 32'd1);
    wr(4'd5, 32'hffff_ffff);
    bus_addr = 4'd5; idle(10);
    lock_phase = 1'b0;

    // R6: single-position windows at the end points
    wr(4'd0, KEY);
    wr(4'd7, {16'd0, 16'd0});
    wr(4'd8, {16'd15, 16'd15});
    wr(4'd1, 32'h1d);
    idle(250);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(WD_LIMIT);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule